// File: doc/BRIEF.md
# Isolated Supply Phase Sequencer

This controller runs one encryption at a time on a crypto core whose supply comes from a local capacitor bank rather than from the chip rails. Each operation passes through three phases in a fixed order. In precharge, the connect switches tie the bank to the external supply and ground. In compute, those switches are open and the bank alone powers the core. In charge share, a discharge switch pulls every capacitor down to a fixed level. The bank therefore draws the same charge at the start of every recharge, whatever work the core did.

An operation starts once a key-ready strobe and a data-ready strobe have both arrived. The two strobes may arrive in either order and in different cycles. While the core computes, a comparator reports that the isolated rails have sagged. The comparator output passes through a two-flop synchronizer. Each sag fires the next stage of a stacked capacitor doubler, one stage at a time. After each firing, a hold-off window stops one sag from firing two stages. A sag that arrives after every stage has fired sets a sticky undervoltage flag and cuts the core clock. The operation is then wound down through charge share.

The analog bank, the comparator, the level shifting and the cipher datapath sit outside this block.

Top module: `iso_phase_seq`

## Requirements
- R1: While reset is held, and after it is released, `hdr_ftr_on`, `share_on`, `core_clk_en`, `done`, `uv_err` and every bit of `boost_en` read 0. The controller rests in an idle phase with all switches open.
- R2: An operation starts only when a `key_rdy` strobe and a `data_rdy` strobe have both been seen since the last start. Each strobe is remembered on its own. `hdr_ftr_on` rises in the cycle after the second of the two strobes.
- R3: Precharge holds `hdr_ftr_on` high for max(`pre_len`,1) consecutive cycles. Compute follows at once.
- R4: `core_clk_en` is high only in compute, and never while `hdr_ftr_on` or `share_on` is high. Compute ends on the first cycle in which `core_busy` is low after being high in compute. `share_on` is high in the following cycle.
- R5: Charge share holds `share_on` high for max(`cs_len`,1) consecutive cycles. `done` is then high for exactly one cycle, in the cycle right after the last charge-share cycle.
- R6: `hdr_ftr_on` and `share_on` are never high in the same cycle. At least one cycle with both low separates the end of charge share from the next precharge.
- R7: With the hold-off expired, a comparator trip fires the next boost stage. The trip is a one-cycle high on `rail_low_raw` during compute. The firing is a one-cycle pulse on `boost_en[i]`, with bit i being stage i. Stages fire in ascending order, at most one bit in any cycle.
- R8: After a stage fires, trips are ignored for `hold_len` cycles. Suppose a trip fires a stage and a second raw trip comes d cycles after the first. It fires the next stage only if d ≥ `hold_len`+1.
- R9: A trip after all N_BOOST stages have fired sets `uv_err`. `uv_err` stays high until reset. `core_clk_en` drops at once, and the operation goes on to charge share and a `done` pulse. No new operation starts while `uv_err` is high.
- R10: Every operation starts its boost sequence again at stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_rdy | input | 1 | Key-ready strobe |
| data_rdy | input | 1 | Data-ready strobe |
| core_busy | input | 1 | Crypto core busy flag |
| rail_low_raw | input | 1 | Asynchronous comparator flag, high when the isolated rails sag |
| pre_len | input | CNT_W | Precharge length in cycles (0 treated as 1) |
| cs_len | input | CNT_W | Charge-share length in cycles (0 treated as 1) |
| hold_len | input | CNT_W | Boost hold-off in cycles |
| hdr_ftr_on | output | 1 | Close the header/footer connect switches |
| boost_en | output | N_BOOST | One-cycle firing pulse per boost stage |
| share_on | output | 1 | Close the charge-share discharge switch |
| core_clk_en | output | 1 | Core clock gate enable |
| done | output | 1 | One-cycle end-of-operation pulse |
| uv_err | output | 1 | Sticky undervoltage flag |

## Verification
The bench sweeps every pair of precharge and charge-share lengths from 0 to 4. This exposes an off-by-one in either counter, or a length of 0 that locks up the sequence. It sweeps the hold-off from 0 to 3 against trip spacings from 1 to 5, which targets the exact d = `hold_len`+1 boundary. A design that miscounts the window fires one stage too many or too few there. It also drives a third trip with both stages spent and checks four things: the clock gate is cut, the operation still completes, later requests are refused, and only reset clears the flag. Alternating which ready strobe arrives first catches a design that needs both strobes in the same cycle.

// File: rtl/iso_seq_pkg.sv
// Shared types for the isolated supply phase sequencer.
package iso_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_COMP  = 2'd2,
        PH_SHARE = 2'd3
    } phase_t;
endpackage

// File: rtl/iso_sync2.sv
// Two-flop synchronizer for a single asynchronous level.
// Assumes the input is held long enough to be seen at the destination clock.
module iso_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;
    logic sync_q;

    // Two-stage capture; both stages clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;
endmodule

// File: rtl/iso_boost_ctl.sv
// Boost stage sequencer: fires stages one at a time on a synchronized trip,
// enforces a hold-off after each firing and raises a sticky undervoltage flag
// when a trip arrives with every stage already spent.
// Assumes 'active' is high only during compute; all progress clears outside it.
module iso_boost_ctl #(
    parameter int N_BOOST = 2,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               trip,
    input  logic [CNT_W-1:0]   hold_len,
    output logic [N_BOOST-1:0] boost_en,
    output logic               uv_err
);
    localparam int IDX_W = $clog2(N_BOOST + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BOOST);

    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   hold_q;
    logic [N_BOOST-1:0] fire_q;
    logic               uv_q;
    logic               ready;
    logic               fire;
    logic               exhaust;

    assign ready   = active && trip && (hold_q == '0);
    assign fire    = ready && (idx_q < LAST_IDX);
    assign exhaust = ready && (idx_q == LAST_IDX);

    // Stage index and hold-off window; cleared whenever compute is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            idx_q  <= '0;
            hold_q <= '0;
        end else if (fire) begin
            idx_q  <= idx_q + 1'b1;
            hold_q <= hold_len;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // One registered firing pulse per stage.
    for (genvar gi = 0; gi < N_BOOST; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) fire_q[gi] <= 1'b0;
            else        fire_q[gi] <= fire && (idx_q == IDX_W'(gi));
        end
    end

    // Sticky undervoltage flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       uv_q <= 1'b0;
        else if (exhaust) uv_q <= 1'b1;
    end

    assign boost_en = fire_q;
    assign uv_err   = uv_q;
endmodule

// File: rtl/iso_phase_seq.sv
// Isolated supply phase sequencer top.
// Runs idle -> precharge -> compute -> charge share -> idle for each operation.
// Assumes core_busy rises only after core_clk_en is granted, and that all
// outputs drive switch/gate controls directly from the registered phase.
module iso_phase_seq
    import iso_seq_pkg::*;
#(
    parameter int N_BOOST = 2,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_rdy,
    input  logic               data_rdy,
    input  logic               core_busy,
    input  logic               rail_low_raw,
    input  logic [CNT_W-1:0]   pre_len,
    input  logic [CNT_W-1:0]   cs_len,
    input  logic [CNT_W-1:0]   hold_len,
    output logic               hdr_ftr_on,
    output logic [N_BOOST-1:0] boost_en,
    output logic               share_on,
    output logic               core_clk_en,
    output logic               done,
    output logic               uv_err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_t           ph_q;
    phase_t           ph_d;
    logic [CNT_W-1:0] cnt_q;
    logic             key_q;
    logic             data_q;
    logic             busy_q;
    logic             done_q;
    logic             rail_low_s;
    logic             start;
    logic             uv_w;

    assign start = (ph_q == PH_IDLE) && !uv_w
                 && (key_q || key_rdy) && (data_q || data_rdy);

    // Synchronize the comparator flag into this clock domain.
    iso_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rail_low_raw),
        .q_sync  (rail_low_s)
    );

    // Boost stage firing, hold-off and undervoltage detection.
    iso_boost_ctl #(
        .N_BOOST (N_BOOST),
        .CNT_W   (CNT_W)
    ) u_boost (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (ph_q == PH_COMP),
        .trip     (rail_low_s),
        .hold_len (hold_len),
        .boost_en (boost_en),
        .uv_err   (uv_w)
    );

    // Remember each ready strobe separately until an operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= 1'b0;
            data_q <= 1'b0;
        end else begin
            key_q  <= (key_q  || key_rdy)  && !start;
            data_q <= (data_q || data_rdy) && !start;
        end
    end

    // Next-phase decision.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (start)                           ph_d = PH_PRE;
            PH_PRE:   if (cnt_q <= ONE)                    ph_d = PH_COMP;
            PH_COMP:  if (uv_w || (busy_q && !core_busy))  ph_d = PH_SHARE;
            PH_SHARE: if (cnt_q <= ONE)                    ph_d = PH_IDLE;
            default:                                       ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Phase duration counter, loaded on entry to precharge and charge share.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cnt_q <= '0;
        else if (start)                                 cnt_q <= pre_len;
        else if (ph_q == PH_COMP && ph_d == PH_SHARE)   cnt_q <= cs_len;
        else if (cnt_q != '0)                           cnt_q <= cnt_q - 1'b1;
    end

    // Busy history, valid only inside compute so a stale level cannot end it.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= (ph_q == PH_COMP) && core_busy;
    end

    // One-cycle completion pulse after the last charge-share cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (ph_q == PH_SHARE) && (ph_d == PH_IDLE);
    end

    assign hdr_ftr_on  = (ph_q == PH_PRE);
    assign share_on    = (ph_q == PH_SHARE);
    assign core_clk_en = (ph_q == PH_COMP) && !uv_w;
    assign done        = done_q;
    assign uv_err      = uv_w;
endmodule

// File: rtl/iso_phase_seq_chk.sv
// Property checker for the phase sequencer, attached by bind below.
// Observes only the top-level ports.
module iso_phase_seq_chk #(
    parameter int N_BOOST = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hdr_ftr_on,
    input logic [N_BOOST-1:0] boost_en,
    input logic               share_on,
    input logic               core_clk_en,
    input logic               done,
    input logic               uv_err
);
    assert_switch_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_ftr_on && share_on));

    assert_dead_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        share_on |=> !hdr_ftr_on);

    assert_clk_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> (!hdr_ftr_on && !share_on));

    assert_boost_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(boost_en));

    assert_done_follows_share_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(share_on) && !share_on));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_uv_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_err |=> uv_err);

    assert_uv_gates_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_err |-> !core_clk_en);
endmodule

bind iso_phase_seq iso_phase_seq_chk #(.N_BOOST(N_BOOST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_ftr_on  (hdr_ftr_on),
    .boost_en    (boost_en),
    .share_on    (share_on),
    .core_clk_en (core_clk_en),
    .done        (done),
    .uv_err      (uv_err)
);

// File: tb/iso_phase_seq_tb_top.sv
// Self-checking bench: sweeps phase lengths and hold-off/trip spacing.
module iso_phase_seq_tb_top;
    localparam int NB = 2;
    localparam int CW = 8;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_rdy = 1'b0, data_rdy = 1'b0, core_busy = 1'b0, rail_low_raw = 1'b0;
    logic [CW-1:0] pre_len = '0, cs_len = '0, hold_len = '0;
    logic hdr_ftr_on, share_on, core_clk_en, done, uv_err;
    logic [NB-1:0] boost_en;

    int total = 0, bad = 0, cyc = 0;
    int n_hdr, n_cs, n_clk, n_done, n_fire;
    int fire_idx [4];
    bit ovl, gapv, dv, multi, prev_cs;

    always #10 clk = ~clk;

    iso_phase_seq #(.N_BOOST(NB), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .key_rdy(key_rdy), .data_rdy(data_rdy),
        .core_busy(core_busy), .rail_low_raw(rail_low_raw),
        .pre_len(pre_len), .cs_len(cs_len), .hold_len(hold_len),
        .hdr_ftr_on(hdr_ftr_on), .boost_en(boost_en), .share_on(share_on),
        .core_clk_en(core_clk_en), .done(done), .uv_err(uv_err));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clr_meas();
        n_hdr = 0; n_cs = 0; n_clk = 0; n_done = 0; n_fire = 0;
        ovl = 0; gapv = 0; dv = 0; multi = 0;
    endtask

    // Port monitor, sampled mid-cycle.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (hdr_ftr_on) n_hdr++;
            if (share_on) n_cs++;
            if (core_clk_en) n_clk++;
            if (done) n_done++;
            if (hdr_ftr_on && share_on) ovl = 1;
            if (prev_cs && hdr_ftr_on) gapv = 1;
            if (done && !prev_cs) dv = 1;
            if ($countones(boost_en) > 1) multi = 1;
            for (int i = 0; i < NB; i++)
                if (boost_en[i] && n_fire < 4) begin fire_idx[n_fire] = i; n_fire++; end
            prev_cs = share_on;
        end else prev_cs = 0;
        if (cyc == LIMIT) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int mx1(input int v); return (v < 1) ? 1 : v; endfunction

    // One operation: strobes, compute with trip pulses, then busy drop.
    task automatic run_op(input int pre, input int cs, input int hold,
                          input int npulse, input int gap, input bit data_first);
        int exp_f;
        pre_len = CW'(pre); cs_len = CW'(cs); hold_len = CW'(hold);
        clr_meas();
        @(negedge clk);
        if (data_first) data_rdy = 1; else key_rdy = 1;
        @(negedge clk); data_rdy = 0; key_rdy = 0;
        repeat (3) @(negedge clk);
        chk(n_hdr == 0, "R2", "no start on one strobe", n_hdr, 0);
        if (data_first) key_rdy = 1; else data_rdy = 1;
        @(negedge clk); data_rdy = 0; key_rdy = 0;
        chk(hdr_ftr_on == 1, "R2", "precharge after both strobes", hdr_ftr_on, 1);
        while (!core_clk_en && cyc < LIMIT) @(negedge clk);
        chk(n_hdr == mx1(pre), "R3", "precharge length", n_hdr, mx1(pre));
        core_busy = 1;
        @(negedge clk);
        for (int p = 0; p < npulse; p++) begin
            rail_low_raw = 1;
            @(negedge clk); rail_low_raw = 0;
            if (p < npulse - 1) repeat (gap - 1) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        if (!uv_err) begin
            chk(core_clk_en == 1, "R4", "clock enabled in compute", core_clk_en, 1);
            core_busy = 0;
            @(negedge clk);
            chk(share_on == 1, "R4", "share after busy drop", share_on, 1);
        end
        core_busy = 0;
        while (n_done == 0 && cyc < LIMIT) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(n_cs == mx1(cs), "R5", "share length", n_cs, mx1(cs));
        chk(n_done == 1 && !dv, "R5", "single done after share", n_done, 1);
        chk(!ovl && !gapv, "R6", "switch overlap/dead cycle", int'(ovl) + int'(gapv), 0);
        if (npulse > 0 && npulse < 3) begin
            exp_f = (npulse == 2 && gap >= hold + 1) ? 2 : 1;
            chk(n_fire == exp_f, "R8", "fires vs hold-off", n_fire, exp_f);
            chk(fire_idx[0] == 0 && !multi, "R10", "first stage is 0", fire_idx[0], 0);
            if (n_fire == 2) chk(fire_idx[1] == 1, "R7", "ascending stage", fire_idx[1], 1);
        end
    endtask

    initial begin
        clr_meas();
        repeat (3) @(negedge clk);
        chk({hdr_ftr_on, share_on, core_clk_en, done, uv_err, boost_en} == '0,
            "R1", "outputs in reset", int'(hdr_ftr_on) + int'(share_on), 0);
        rst_n = 1;
        @(negedge clk);
        chk({hdr_ftr_on, share_on, core_clk_en, done, uv_err, boost_en} == '0,
            "R1", "idle after reset", int'(core_clk_en) + int'(uv_err), 0);

        // Phase length sweep, strobe order alternating.
        for (int p = 0; p <= 4; p++)
            for (int c = 0; c <= 4; c++)
                run_op(p, c, 0, 0, 1, bit'((p + c) % 2));

        // Hold-off against trip spacing sweep.
        for (int h = 0; h <= 3; h++)
            for (int d = 1; d <= 5; d++)
                run_op(2, 2, h, 2, d, 1'b0);

        // Undervoltage: third trip after both stages spent.
        run_op(1, 2, 1, 3, 4, 1'b0);
        chk(uv_err == 1, "R9", "undervoltage flag set", uv_err, 1);
        chk(n_fire == 2, "R7", "only N stages fired", n_fire, 2);
        clr_meas();
        @(negedge clk); key_rdy = 1; data_rdy = 1;
        @(negedge clk); key_rdy = 0; data_rdy = 0;
        repeat (20) @(negedge clk);
        chk(n_hdr == 0 && n_clk == 0, "R9", "no start while flagged", n_hdr + n_clk, 0);
        chk(uv_err == 1, "R9", "flag sticky", uv_err, 1);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(uv_err == 0, "R1", "reset clears flag", uv_err, 0);
        run_op(1, 1, 0, 1, 1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule